// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a core's register datapath and a byte-addressed memory bus whose width is a whole number of bytes (32 bits by default). For every access it takes the byte offset of the address inside the bus word, the access size and the current byte order. From these it works out which byte lanes of the bus take part. For a store it copies the narrow write value into every lane and raises the byte enables of the addressed lane or lanes only. For a load it takes the addressed byte or halfword out of the word read from the bus and widens it to the full width, filling with zeros or with copies of its top bit.

The byte order comes from a mode input that may change between accesses. In little-endian order, the byte at the lowest address of a word sits in the least significant lane. In big-endian order, that byte sits in the most significant lane. An access that does not start on a multiple of its own size is reported as an alignment error, and it produces no byte enables and no data. Every result is registered, so it appears one clock after its request.

Top module: `aln_byte_aligner`

## Requirements
- R1: While reset is low, every output of the block is zero, including an access that is in flight when reset arrives.
- R2: The outputs for a request appear exactly one clock after the request. `out_valid_o` follows `req_valid_i` with that one-clock delay. A cycle with no request produces zero byte enables, no error and zero data.
- R3: The size code is 0 for byte, 1 for halfword, 2 for word, and 3 is reserved on a 32-bit bus. A halfword with an odd offset, a word with a nonzero offset, or the reserved code raises `align_err_o`. Such an access drives all byte enables and both data outputs to zero.
- R4: In little-endian mode (`big_endian_i` = 0), a byte access at offset k enables lane k alone, where lane k is bits [8k+7:8k].
- R5: In big-endian mode (`big_endian_i` = 1), a byte access at offset k enables lane 3−k alone.
- R6: A halfword at offset 0 enables lanes 1:0 in little-endian mode and lanes 3:2 in big-endian mode. A halfword at offset 2 enables lanes 3:2 in little-endian mode and lanes 1:0 in big-endian mode.
- R7: A word access enables all four lanes in both modes. A word store drives the write value unchanged, and a word load returns the read word unchanged.
- R8: A byte store drives its low 8 bits into all four lanes. A halfword store drives its low 16 bits into both halves.
- R9: An unsigned load (`req_signed_i` = 0) returns the selected byte or halfword in the low bits, with zeros above.
- R10: A signed load (`req_signed_i` = 1) fills the bits above the selected byte or halfword with its most significant bit.
- R11: A load drives `bus_wdata_o` to zero. A store drives `load_data_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| big_endian_i | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_write_i | input | 1 | 1 for a store, 0 for a load |
| req_signed_i | input | 1 | Sign-extend a narrow load |
| req_size_i | input | 2 | Access size code (0 byte, 1 halfword, 2 word, 3 reserved on a 32-bit bus) |
| req_ofs_i | input | clog2(DATA_W/8) | Byte offset of the address within the bus word |
| req_wdata_i | input | DATA_W | Store value, right-justified |
| bus_rdata_i | input | DATA_W | Word read from the bus for a load in the same cycle |
| out_valid_o | output | 1 | Registered copy of `req_valid_i` |
| bus_be_o | output | DATA_W/8 | Byte enables, one per lane |
| bus_wdata_o | output | DATA_W | Store data placed on the lanes |
| load_data_o | output | DATA_W | Extracted and extended load value |
| align_err_o | output | 1 | The access was misaligned or had an unsupported size |

## Verification
The block keeps no state other than its output register, so any internal fault shows at the ports in the very next cycle after the request that exposes it. A wrong lane base shows as byte enables on the mirror lane and as the wrong byte in `load_data_o`. A wrong fill bit shows in the upper bits of a load of a byte whose top bit is set. A wrong alignment test shows as an error flag together with missing enables, or as enables on a bad offset. The stimulus pairs each offset with both byte orders, and uses read data whose lanes hold four distinct bytes with the top bit both set and clear, so a swapped lane or a wrong fill cannot go unseen.

// File: rtl/aln_pkg.sv
package aln_pkg;

   // Access size codes; the number of bytes is 1 << code.
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

endpackage

// File: rtl/aln_lane_map.sv
module aln_lane_map #(
   parameter int LANES = 4,
   parameter int OFS_W = 2
) (
   input  logic                 big_i,
   input  aln_pkg::acc_size_e   size_i,
   input  logic [OFS_W-1:0]     ofs_i,
   output logic [OFS_W-1:0]     base_o,
   output logic [LANES-1:0]     mask_o,
   output logic                 misalign_o
);

   int nbytes;
   int base_n;

   always_comb begin
      nbytes     = 1 << int'(size_i);
      // Offset must be a multiple of the access size; sizes wider than the bus are refused.
      misalign_o = (nbytes > LANES) || ((int'(ofs_i) & (nbytes - 1)) != 0);
      // Big-endian mirrors the position of the access inside the word.
      base_n     = big_i ? (int'(ofs_i) ^ (LANES - nbytes)) : int'(ofs_i);
      base_o     = base_n[OFS_W-1:0];
      mask_o     = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!misalign_o && (i >= base_n) && (i < base_n + nbytes))
            mask_o[i] = 1'b1;
      end
   end

endmodule

// File: rtl/aln_store_path.sv
module aln_store_path #(
   parameter int DATA_W = 32
) (
   input  aln_pkg::acc_size_e   size_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rep_o
);

   localparam int LANES = DATA_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_byte;
      always_comb begin
         case (size_i)
            aln_pkg::SZ_BYTE: lane_byte = wdata_i[7:0];
            aln_pkg::SZ_HALF: lane_byte = wdata_i[8*(g%2) +: 8];
            aln_pkg::SZ_WORD: lane_byte = wdata_i[8*(g%4) +: 8];
            default:          lane_byte = wdata_i[8*g +: 8];
         endcase
      end
      assign rep_o[8*g +: 8] = lane_byte;
   end

endmodule

// File: rtl/aln_load_path.sv
module aln_load_path #(
   parameter int DATA_W = 32,
   parameter int OFS_W  = 2
) (
   input  logic [DATA_W-1:0]    rdata_i,
   input  logic [OFS_W-1:0]     base_i,
   input  aln_pkg::acc_size_e   size_i,
   input  logic                 sgn_i,
   output logic [DATA_W-1:0]    ext_o
);

   logic [DATA_W-1:0] shifted;
   logic              top_bit;
   int                nbits;

   always_comb begin
      shifted = rdata_i >> {base_i, 3'b000};
      nbits   = 8 << int'(size_i);
      if (nbits > DATA_W) nbits = DATA_W;
      top_bit = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i == nbits - 1) top_bit = shifted[i];
      end
      for (int i = 0; i < DATA_W; i++) begin
         ext_o[i] = (i < nbits) ? shifted[i] : (sgn_i & top_bit);
      end
   end

endmodule

// File: rtl/aln_byte_aligner.sv
module aln_byte_aligner #(
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          big_endian_i,
   input  logic                          req_valid_i,
   input  logic                          req_write_i,
   input  logic                          req_signed_i,
   input  logic [1:0]                    req_size_i,
   input  logic [$clog2(DATA_W/8)-1:0]   req_ofs_i,
   input  logic [DATA_W-1:0]             req_wdata_i,
   input  logic [DATA_W-1:0]             bus_rdata_i,
   output logic                          out_valid_o,
   output logic [DATA_W/8-1:0]           bus_be_o,
   output logic [DATA_W-1:0]             bus_wdata_o,
   output logic [DATA_W-1:0]             load_data_o,
   output logic                          align_err_o
);

   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = $clog2(LANES);

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("aln_byte_aligner: DATA_W must be 32 or 64");
   end

   aln_pkg::acc_size_e   size_e;
   logic [OFS_W-1:0]     lane_base;
   logic [LANES-1:0]     lane_mask;
   logic                 misalign;
   logic [DATA_W-1:0]    rep_data;
   logic [DATA_W-1:0]    ext_data;

   assign size_e = aln_pkg::acc_size_e'(req_size_i);

   aln_lane_map #(.LANES(LANES), .OFS_W(OFS_W)) u_map (
      .big_i      (big_endian_i),
      .size_i     (size_e),
      .ofs_i      (req_ofs_i),
      .base_o     (lane_base),
      .mask_o     (lane_mask),
      .misalign_o (misalign)
   );

   aln_store_path #(.DATA_W(DATA_W)) u_store (
      .size_i  (size_e),
      .wdata_i (req_wdata_i),
      .rep_o   (rep_data)
   );

   aln_load_path #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_load (
      .rdata_i (bus_rdata_i),
      .base_i  (lane_base),
      .size_i  (size_e),
      .sgn_i   (req_signed_i),
      .ext_o   (ext_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         bus_be_o    <= '0;
         bus_wdata_o <= '0;
         load_data_o <= '0;
         align_err_o <= 1'b0;
      end else begin
         out_valid_o <= req_valid_i;
         align_err_o <= req_valid_i & misalign;
         bus_be_o    <= req_valid_i ? lane_mask : '0;
         bus_wdata_o <= (req_valid_i && req_write_i && !misalign) ? rep_data : '0;
         load_data_o <= (req_valid_i && !req_write_i && !misalign) ? ext_data : '0;
      end
   end

   // R3: an error never comes with lane enables
   p_err_no_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      align_err_o |-> (bus_be_o == '0));

   // R2: one-cycle latency and quiet idle
   p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> out_valid_o);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> (bus_be_o == '0) && !align_err_o);

   // R4/R5: a byte access owns exactly one lane
   p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_size_i == 2'd0) |=> ($countones(bus_be_o) == 1) && !align_err_o);

   // R6: an even halfword owns exactly two lanes
   p_half_two_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_size_i == 2'd1 && !req_ofs_i[0]) |=> ($countones(bus_be_o) == 2));

   // R7: aligned word store passes data through
   p_word_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_write_i && req_size_i == 2'd2 && req_ofs_i == '0)
      |=> (bus_wdata_o == $past(req_wdata_i)));

   // R9: unsigned byte load has zero upper bits
   p_ubyte_zero_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !req_write_i && !req_signed_i && req_size_i == 2'd0)
      |=> (load_data_o[DATA_W-1:8] == '0));

   // R11: loads leave the write bus at zero
   p_read_no_wdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !req_write_i) |=> (bus_wdata_o == '0));

endmodule

// File: tb/tb_aln_byte_aligner.sv
`timescale 1ns/1ps
module tb_aln_byte_aligner;

   localparam logic [31:0] WD = 32'hA1B2C3D4;
   localparam logic [31:0] RD = 32'h8F7E6D5C;

   typedef struct packed {
      logic        big;
      logic        wr;
      logic        sgn;
      logic [1:0]  size;
      logic [1:0]  ofs;
      logic [3:0]  be;
      logic        err;
      logic [31:0] ewd;
      logic [31:0] eld;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,1'b0,2'd0,2'd0,4'b0001,1'b0,32'hD4D4D4D4,32'h0,8'd4},  // R4
      '{1'b0,1'b1,1'b0,2'd0,2'd3,4'b1000,1'b0,32'hD4D4D4D4,32'h0,8'd4},  // R4
      '{1'b1,1'b1,1'b0,2'd0,2'd0,4'b1000,1'b0,32'hD4D4D4D4,32'h0,8'd5},  // R5
      '{1'b1,1'b1,1'b0,2'd0,2'd2,4'b0010,1'b0,32'hD4D4D4D4,32'h0,8'd5},  // R5
      '{1'b0,1'b1,1'b0,2'd1,2'd2,4'b1100,1'b0,32'hC3D4C3D4,32'h0,8'd8},  // R8
      '{1'b1,1'b1,1'b0,2'd1,2'd0,4'b1100,1'b0,32'hC3D4C3D4,32'h0,8'd6},  // R6
      '{1'b1,1'b1,1'b0,2'd1,2'd2,4'b0011,1'b0,32'hC3D4C3D4,32'h0,8'd6},  // R6
      '{1'b0,1'b0,1'b0,2'd1,2'd0,4'b0011,1'b0,32'h0,32'h00006D5C,8'd6},  // R6
      '{1'b0,1'b1,1'b0,2'd2,2'd0,4'b1111,1'b0,32'hA1B2C3D4,32'h0,8'd7},  // R7
      '{1'b1,1'b1,1'b0,2'd2,2'd0,4'b1111,1'b0,32'hA1B2C3D4,32'h0,8'd7},  // R7
      '{1'b0,1'b0,1'b0,2'd0,2'd3,4'b1000,1'b0,32'h0,32'h0000008F,8'd9},  // R9
      '{1'b0,1'b0,1'b1,2'd0,2'd3,4'b1000,1'b0,32'h0,32'hFFFFFF8F,8'd10}, // R10
      '{1'b1,1'b0,1'b1,2'd0,2'd0,4'b1000,1'b0,32'h0,32'hFFFFFF8F,8'd10}, // R10
      '{1'b1,1'b0,1'b0,2'd0,2'd3,4'b0001,1'b0,32'h0,32'h0000005C,8'd5},  // R5
      '{1'b0,1'b0,1'b1,2'd1,2'd0,4'b0011,1'b0,32'h0,32'h00006D5C,8'd10}, // R10
      '{1'b1,1'b0,1'b1,2'd1,2'd0,4'b1100,1'b0,32'h0,32'hFFFF8F7E,8'd10}, // R10
      '{1'b0,1'b0,1'b0,2'd1,2'd2,4'b1100,1'b0,32'h0,32'h00008F7E,8'd9},  // R9
      '{1'b1,1'b0,1'b0,2'd0,2'd1,4'b0100,1'b0,32'h0,32'h0000007E,8'd9},  // R9
      '{1'b0,1'b0,1'b1,2'd0,2'd1,4'b0010,1'b0,32'h0,32'h0000006D,8'd10}, // R10
      '{1'b0,1'b1,1'b0,2'd1,2'd1,4'b0000,1'b1,32'h0,32'h0,8'd3},         // R3
      '{1'b0,1'b0,1'b1,2'd2,2'd2,4'b0000,1'b1,32'h0,32'h0,8'd3},         // R3
      '{1'b1,1'b0,1'b0,2'd3,2'd0,4'b0000,1'b1,32'h0,32'h0,8'd3},         // R3
      '{1'b1,1'b0,1'b1,2'd2,2'd0,4'b1111,1'b0,32'h0,32'h8F7E6D5C,8'd7},  // R7
      '{1'b1,1'b1,1'b0,2'd2,2'd1,4'b0000,1'b1,32'h0,32'h0,8'd3}          // R3
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian_i = 1'b0;
   logic        req_valid_i = 1'b0;
   logic        req_write_i = 1'b0;
   logic        req_signed_i = 1'b0;
   logic [1:0]  req_size_i = 2'd0;
   logic [1:0]  req_ofs_i = 2'd0;
   logic [31:0] req_wdata_i = WD;
   logic [31:0] bus_rdata_i = RD;
   logic        out_valid_o;
   logic [3:0]  bus_be_o;
   logic [31:0] bus_wdata_o;
   logic [31:0] load_data_o;
   logic        align_err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   aln_byte_aligner dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .big_endian_i (big_endian_i),
      .req_valid_i  (req_valid_i),
      .req_write_i  (req_write_i),
      .req_signed_i (req_signed_i),
      .req_size_i   (req_size_i),
      .req_ofs_i    (req_ofs_i),
      .req_wdata_i  (req_wdata_i),
      .bus_rdata_i  (bus_rdata_i),
      .out_valid_o  (out_valid_o),
      .bus_be_o     (bus_be_o),
      .bus_wdata_o  (bus_wdata_o),
      .load_data_o  (load_data_o),
      .align_err_o  (align_err_o)
   );

   task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      big_endian_i = v.big;
      req_valid_i  = 1'b1;
      req_write_i  = v.wr;
      req_signed_i = v.sgn;
      req_size_i   = v.size;
      req_ofs_i    = v.ofs;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(1, "valid in reset", {31'b0, out_valid_o}, 32'h0);
      chk(1, "be in reset", {28'b0, bus_be_o}, 32'h0);
      chk(1, "wdata in reset", bus_wdata_o, 32'h0);
      chk(1, "load in reset", load_data_o, 32'h0);
      chk(1, "err in reset", {31'b0, align_err_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: request at one negedge, result checked at the next.
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         chk(int'(VECS[i].rq), "be",    {28'b0, bus_be_o},    {28'b0, VECS[i].be});
         chk(int'(VECS[i].rq), "err",   {31'b0, align_err_o}, {31'b0, VECS[i].err});
         chk(int'(VECS[i].rq), "wdata", bus_wdata_o,          VECS[i].ewd);
         chk(int'(VECS[i].rq), "load",  load_data_o,          VECS[i].eld);
         chk(2, "valid", {31'b0, out_valid_o}, 32'h1);   // R2
      end

      // R2: idle cycle after a request
      req_valid_i = 1'b0;
      @(negedge clk);
      chk(2, "idle valid", {31'b0, out_valid_o}, 32'h0);
      chk(2, "idle be", {28'b0, bus_be_o}, 32'h0);
      chk(2, "idle err", {31'b0, align_err_o}, 32'h0);

      // R11: load with write data present, then store with read data present
      drive('{1'b0,1'b0,1'b0,2'd2,2'd0,4'b0,1'b0,32'h0,32'h0,8'd11});
      req_wdata_i = 32'hFFFFFFFF;
      @(negedge clk);
      chk(11, "wdata on load", bus_wdata_o, 32'h0);
      chk(11, "load on load", load_data_o, RD);
      drive('{1'b1,1'b1,1'b1,2'd0,2'd2,4'b0,1'b0,32'h0,32'h0,8'd11});
      req_wdata_i = 32'h0000005A;
      @(negedge clk);
      chk(11, "load on store", load_data_o, 32'h0);
      chk(8, "byte replicate", bus_wdata_o, 32'h5A5A5A5A);
      chk(5, "be big byte ofs2", {28'b0, bus_be_o}, 32'h2);

      // R1: reset arriving with a request held
      drive('{1'b0,1'b0,1'b1,2'd0,2'd3,4'b0,1'b0,32'h0,32'h0,8'd1});
      rst_n = 1'b0;
      @(negedge clk);
      chk(1, "be under reset", {28'b0, bus_be_o}, 32'h0);
      chk(1, "load under reset", load_data_o, 32'h0);
      chk(1, "valid under reset", {31'b0, out_valid_o}, 32'h0);
      req_valid_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule